// File: doc/BRIEF.md
# Serial Audio Control Word Receiver

This block receives control words for a headphone audio path over a three-wire host port made of a data line, a shift clock and a latch strobe. All three lines are sampled by the faster system clock. Bits enter most-significant first on each rising shift-clock edge. A rising latch edge commits the bits gathered so far to a holding register, and the held word drives the decoded audio settings. The host may send more than sixteen clocks per transfer; only the final sixteen bits count.

The held word is decoded into several settings: automatic-gain-control enable, bass-boost enable and boost mode, and input-pair select. An 8-bit attenuation code is turned into an attenuation in dB, a total output gain in dB (attenuation plus a fixed 12 dB amplifier gain) and a volume-mute flag. A mute pin and a power-down pin are combined with the volume mute to give an effective mute flag and an output high-impedance flag. The port carries no data stream, so every pin is a plain level with no handshake. An active-low reset loads a safe default word.

Top module: `audio_ctl_rx`

## Requirements
- R1: Bits are shifted in most-significant first on each rising edge of `ser_clk`. The decoded outputs change only after a rising edge of `ser_latch`, which commits the shifted bits.
- R2: When more than 16 shift clocks come before the latch, only the last 16 bits shifted in take effect.
- R3: Word bit 11 drives `agc_en` (1 = on). Word bits 15 to 12 have no effect on any output.
- R4: `boost_en` follows word bit 9 (0 = boost off). `boost_mode` follows word bit 10: 0 selects mode 1 and 1 selects mode 2.
- R5: `src_sel` follows word bit 8: 0 selects input pair 1 and 1 selects input pair 2.
- R6: For attenuation code bits 7..0 in the range 0x00 to 0x50, `atten_db` equals the code and `vol_mute` is 0. For codes 0x51 to 0xFF, `vol_mute` is 1 and `atten_db` is 0.
- R7: When `vol_mute` is 0, `gain_db` equals 12 minus the code, as a two's-complement signed value (+12 down to -68). When `vol_mute` is 1, `gain_db` is 0.
- R8: While `rst_n` is low, the held word is 0x00FF. This gives AGC off, boost off with mode 1, input pair 1, and volume muted.
- R9: `mute_eff` is 1 when `vol_mute` is 1, when `mute_n` is low, or when `pdn_n` is low.
- R10: `out_hiz` is 1 when `pdn_n` is low or `vol_mute` is 1. A low `mute_n` alone leaves `out_hiz` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Host shift clock |
| ser_data | input | 1 | Host serial data, MSB first |
| ser_latch | input | 1 | Host latch strobe, commits on rising edge |
| mute_n | input | 1 | Mute pin, low forces mute |
| pdn_n | input | 1 | Power-down pin, low forces high impedance |
| agc_en | output | 1 | Automatic gain control enable |
| boost_en | output | 1 | Bass boost enable |
| boost_mode | output | 1 | Boost mode, 0 = mode 1, 1 = mode 2 |
| src_sel | output | 1 | Input pair select, 0 = pair 1, 1 = pair 2 |
| atten_db | output | 7 | Attenuation in dB, valid when not muted |
| gain_db | output | 8 | Signed total output gain in dB |
| vol_mute | output | 1 | Attenuation code selects mute |
| mute_eff | output | 1 | Effective mute |
| out_hiz | output | 1 | Outputs held in high impedance |

## Verification
The hardest case to reach from the ports is an over-long transfer. In that case the committed word must come from the tail of the bit stream, not the head. The stimulus sends 20 clocks whose first four bits would, if kept, set AGC and boost. After the latch it checks that only the last sixteen bits count. Sequences that differ only in bits 15 to 12, and codes on both sides of the 0x50 mute boundary, are compared with a behavioural model on every settled clock.

// File: rtl/audio_ctl_pkg.sv
package audio_ctl_pkg;
  localparam int WORD_W     = 16;
  localparam int KEEP_W     = 12;
  localparam int CODE_W     = 8;
  localparam int ATTEN_W    = 7;
  localparam int GAIN_W     = 8;
  localparam int BIT_AGC    = 11;
  localparam int BIT_BMODE  = 10;
  localparam int BIT_BOOST  = 9;
  localparam int BIT_SRC    = 8;
  localparam int MAX_ATTEN  = 80;
  localparam int HPA_GAIN   = 12;
  localparam logic [KEEP_W-1:0] RESET_WORD = 12'h0FF;

  typedef struct packed {
    logic agc;
    logic boost;
    logic bmode;
    logic src;
  } ctl_flags_t;
endpackage

// File: rtl/audio_ctl_sync.sv
module audio_ctl_sync #(
  parameter int N      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_in,
  output logic [N-1:0] d_out
);
  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_in[gi]};
      end
      assign d_out[gi] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/audio_ctl_capture.sv
module audio_ctl_capture
  import audio_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sdat_s,
  input  logic              slat_s,
  output logic [KEEP_W-1:0] hold_q
);
  logic              sclk_q, slat_q;
  logic              sclk_rise, slat_rise;
  logic [KEEP_W-1:0] shift_q;

  assign sclk_rise = sclk_s & ~sclk_q;
  assign slat_rise = slat_s & ~slat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      slat_q <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      slat_q <= slat_s;
    end
  end

  // Only the low KEEP_W bits of the last WORD_W shifted are ever decoded,
  // so older bits fall off the top of a shorter register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shift_q <= RESET_WORD;
    else if (sclk_rise) shift_q <= {shift_q[KEEP_W-2:0], sdat_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hold_q <= RESET_WORD;
    else if (slat_rise) hold_q <= shift_q;
  end

  // R1: the held word moves only on a latch edge
  p_hold_only_on_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !slat_rise |=> $stable(hold_q));

  // R1: older bits move one place toward the MSB on a shift edge
  p_shift_msb_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> shift_q[KEEP_W-1:1] == $past(shift_q[KEEP_W-2:0]));

  // R8: the default word is in place when reset is released
  p_reset_default_r8: assert property (@(posedge clk)
    $rose(rst_n) |-> hold_q == RESET_WORD);
endmodule

// File: rtl/audio_ctl_decode.sv
module audio_ctl_decode
  import audio_ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [KEEP_W-1:0]  word,
  input  logic               mute_ns,
  input  logic               pdn_ns,
  output ctl_flags_t         flags,
  output logic [ATTEN_W-1:0] atten_db,
  output logic [GAIN_W-1:0]  gain_db,
  output logic               vol_mute,
  output logic               mute_eff,
  output logic               out_hiz
);
  localparam logic [CODE_W-1:0] CODE_MAX = CODE_W'(MAX_ATTEN);
  localparam logic [GAIN_W-1:0] G_OFS    = GAIN_W'(HPA_GAIN);

  logic [CODE_W-1:0] code;

  assign code = word[CODE_W-1:0];

  always_comb begin
    flags.agc   = word[BIT_AGC];
    flags.boost = word[BIT_BOOST];
    flags.bmode = word[BIT_BMODE];
    flags.src   = word[BIT_SRC];
  end

  always_comb begin
    vol_mute = (code > CODE_MAX);
    if (vol_mute) begin
      atten_db = '0;
      gain_db  = '0;
    end else begin
      atten_db = code[ATTEN_W-1:0];
      gain_db  = G_OFS - {{(GAIN_W-ATTEN_W){1'b0}}, code[ATTEN_W-1:0]};
    end
  end

  assign mute_eff = vol_mute | ~mute_ns | ~pdn_ns;
  assign out_hiz  = vol_mute | ~pdn_ns;

  // R6: a muted code reports zero attenuation and zero gain
  p_mute_zeroes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vol_mute |-> (atten_db == '0) && (gain_db == '0));

  // R7: gain and attenuation always add up to the amplifier gain
  p_gain_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !vol_mute |-> (gain_db + {1'b0, atten_db}) == G_OFS);

  // R10: power-down implies high impedance and mute
  p_pdn_hiz_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pdn_ns |-> out_hiz && mute_eff);

  // R9: mute pin low never leaves the effective mute clear
  p_pin_mute_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mute_ns |-> mute_eff);
endmodule

// File: rtl/audio_ctl_rx.sv
module audio_ctl_rx
  import audio_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk,
  input  logic               ser_data,
  input  logic               ser_latch,
  input  logic               mute_n,
  input  logic               pdn_n,
  output logic               agc_en,
  output logic               boost_en,
  output logic               boost_mode,
  output logic               src_sel,
  output logic [ATTEN_W-1:0] atten_db,
  output logic [GAIN_W-1:0]  gain_db,
  output logic               vol_mute,
  output logic               mute_eff,
  output logic               out_hiz
);
  localparam int NSYNC = 5;

  logic [NSYNC-1:0]  pins_s;
  logic [KEEP_W-1:0] hold_w;
  ctl_flags_t        flags_w;

  audio_ctl_sync #(.N(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({pdn_n, mute_n, ser_latch, ser_data, ser_clk}),
    .d_out (pins_s)
  );

  audio_ctl_capture u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk_s (pins_s[0]),
    .sdat_s (pins_s[1]),
    .slat_s (pins_s[2]),
    .hold_q (hold_w)
  );

  audio_ctl_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .word     (hold_w),
    .mute_ns  (pins_s[3]),
    .pdn_ns   (pins_s[4]),
    .flags    (flags_w),
    .atten_db (atten_db),
    .gain_db  (gain_db),
    .vol_mute (vol_mute),
    .mute_eff (mute_eff),
    .out_hiz  (out_hiz)
  );

  assign agc_en     = flags_w.agc;
  assign boost_en   = flags_w.boost;
  assign boost_mode = flags_w.bmode;
  assign src_sel    = flags_w.src;
endmodule

// File: tb/tb_audio_ctl_rx.sv
module tb_audio_ctl_rx;
  localparam int CLK_P  = 10;
  localparam int HALF   = 4;
  localparam int SETTLE = 6;

  logic clk = 1'b0;
  logic rst_n, ser_clk, ser_data, ser_latch, mute_n, pdn_n;
  logic agc_en, boost_en, boost_mode, src_sel, vol_mute, mute_eff, out_hiz;
  logic [6:0] atten_db;
  logic [7:0] gain_db;

  int checks = 0;
  int fails  = 0;
  int settle = SETTLE;
  bit done   = 0;
  logic [15:0] m_shift = 16'h00FF;
  logic [15:0] m_hold  = 16'h00FF;

  always #(CLK_P/2) clk = ~clk;

  audio_ctl_rx dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_latch(ser_latch), .mute_n(mute_n), .pdn_n(pdn_n),
    .agc_en(agc_en), .boost_en(boost_en), .boost_mode(boost_mode),
    .src_sel(src_sel), .atten_db(atten_db), .gain_db(gain_db),
    .vol_mute(vol_mute), .mute_eff(mute_eff), .out_hiz(out_hiz)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    int code, em, ea, eg;
    code = int'(m_hold[7:0]);
    em = (code > 80) ? 1 : 0;
    ea = em ? 0 : code;
    eg = em ? 0 : ((12 - code) & 8'hFF);
    chk("R3 agc_en",     int'(agc_en),     int'(m_hold[11]));
    chk("R4 boost_en",   int'(boost_en),   int'(m_hold[9]));
    chk("R4 boost_mode", int'(boost_mode), int'(m_hold[10]));
    chk("R5 src_sel",    int'(src_sel),    int'(m_hold[8]));
    chk("R6 vol_mute",   int'(vol_mute),   em);
    chk("R6 atten_db",   int'(atten_db),   ea);
    chk("R7 gain_db",    int'(gain_db),    eg);
    chk("R9 mute_eff",   int'(mute_eff),   (em | int'(!mute_n) | int'(!pdn_n)));
    chk("R10 out_hiz",   int'(out_hiz),    (em | int'(!pdn_n)));
  endtask

  // per-clock comparison once the synchronizers have settled
  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) settle <= SETTLE;
      else if (settle > 0) settle <= settle - 1;
      else compare_all();
    end
  end

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = v[i];
      wait_clks(HALF);
      ser_clk = 1'b1;
      m_shift = {m_shift[14:0], v[i]};
      wait_clks(HALF);
      ser_clk = 1'b0;
    end
  endtask

  task automatic latch();
    wait_clks(HALF);
    ser_latch = 1'b1;
    m_hold = m_shift;
    settle = SETTLE;
    wait_clks(HALF);
    ser_latch = 1'b0;
    wait_clks(SETTLE + 2);
  endtask

  task automatic send(input logic [15:0] w);
    shift_bits({16'h0, w}, 16);
    latch();
  endtask

  task automatic set_pins(input logic m, input logic p);
    mute_n = m;
    pdn_n  = p;
    settle = SETTLE;
    wait_clks(SETTLE + 4);
  endtask

  initial begin
    rst_n = 1'b0; ser_clk = 1'b0; ser_data = 1'b0; ser_latch = 1'b0;
    mute_n = 1'b1; pdn_n = 1'b1;
    wait_clks(3);
    // R8: defaults while reset is held
    chk("R8 agc_en reset",   int'(agc_en),     0);
    chk("R8 boost_en reset", int'(boost_en),   0);
    chk("R8 mode reset",     int'(boost_mode), 0);
    chk("R8 src reset",      int'(src_sel),    0);
    chk("R8 mute reset",     int'(vol_mute),   1);
    rst_n = 1'b1;
    wait_clks(SETTLE + 4);

    send(16'h0A05);                 // R3 agc on, R4 mode 1, code 5
    // R1: shifting without latch leaves outputs alone
    shift_bits({16'h0, 16'h0700}, 16);
    wait_clks(4);
    chk("R1 no commit before latch", int'(atten_db), 5);
    latch();
    chk("R1 commit after latch", int'(atten_db), 0);
    chk("R4 mode 2 after latch", int'(boost_mode), 1);

    send(16'h0650);                 // R6 boundary 80, R4 mode 2
    chk("R7 gain at code 0x50", int'(gain_db), 8'hBC);
    send(16'h0151);                 // R6 first mute code, R5 pair 2
    chk("R6 mute at 0x51", int'(vol_mute), 1);
    send(16'hF000);                 // R3 top bits ignored, code 0
    chk("R3 agc unaffected by bits 15..12", int'(agc_en), 0);
    chk("R7 gain +12", int'(gain_db), 12);
    send(16'h004F);
    send(16'h04FF);                 // R4 bit10 alone: boost off
    chk("R4 boost off with bit 10 only", int'(boost_en), 0);

    // R2: 20 clocks, first four would set agc/boost if kept in place
    shift_bits(32'h000F0B20, 20);
    latch();
    chk("R2 tail kept agc", int'(agc_en), 1);
    chk("R2 tail kept code", int'(atten_db), 32);

    send(16'h0014);
    set_pins(1'b0, 1'b1);           // R9 pin mute, R10 stays driven
    chk("R10 mute pin keeps driven", int'(out_hiz), 0);
    chk("R9 mute pin mutes", int'(mute_eff), 1);
    set_pins(1'b1, 1'b0);
    chk("R10 power-down hiz", int'(out_hiz), 1);
    set_pins(1'b0, 1'b0);
    set_pins(1'b1, 1'b1);
    send(16'h00FF);
    chk("R10 code mute hiz", int'(out_hiz), 1);

    // R8: reset mid-operation restores defaults
    send(16'h0F10);
    rst_n = 1'b0;
    m_shift = 16'h00FF; m_hold = 16'h00FF;
    wait_clks(2);
    chk("R8 reset restores mute", int'(vol_mute), 1);
    chk("R8 reset restores src", int'(src_sel), 0);
    rst_n = 1'b1;
    wait_clks(SETTLE + 4);
    send(16'h0300);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule